// File: doc/BRIEF.md
# Bi-phase Transition Line Encoder

This block turns a stream of bytes into a single self-clocking serial line. Each byte is wrapped in a ten-bit frame: a start bit of value 0, the eight data bits least significant first, and a stop bit of value 1. The line does not carry the bit value as a level. The output is inverted at the end of every bit interval, and the value of a bit is given by how long that interval lasts. A '1' takes `BIT1_CYC` clock cycles and a '0' takes `BIT0_CYC` cycles.

Because every interval ends in an inversion, the line never rests at a DC level. This holds even for long runs of identical bits and while no data is waiting. When idle, the encoder keeps sending stop-bit intervals. Bytes enter through a valid/ready handshake. A byte is taken only at a frame boundary, so back-to-back bytes leave the encoder with no gap between frames.

Top module: `biphase_line_enc`

## Requirements
- R1: A frame is ten intervals: one start bit of value 0, then data bits 0 through 7 of the accepted byte (bit 0 first), then one stop bit of value 1.
- R2: `line_out` inverts at the clock edge that ends each interval, whatever the bit value, and never changes at any other edge.
- R3: An interval for a '1' bit lasts `BIT1_CYC` cycles and an interval for a '0' bit lasts `BIT0_CYC` cycles (defaults 4 and 8).
- R4: Bytes made of identical bits (0x00, 0xFF) still give an inversion at every interval end, so the line toggles ten times per frame.
- R5: With no byte offered at a frame boundary, the encoder sends idle intervals of `BIT1_CYC` cycles each and keeps toggling.
- R6: `in_ready` is high for exactly one cycle per interval that ends a frame or an idle interval, namely its last cycle. The byte is taken when `in_valid` and `in_ready` are both high, and its frame starts with the next interval, so held-valid bytes follow each other with no idle interval.
- R7: Reset is synchronous and active high. During reset `line_out` is 0 and `in_ready` is 0. The first inversion comes `BIT1_CYC` cycles after the last reset edge, and `in_ready` is first high in the cycle before that edge.
- R8: `in_valid` and `in_data` offered in the middle of a frame are ignored. The frame in flight keeps its intervals, and a pulse that is withdrawn before the boundary starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | Byte to encode |
| in_ready | output | 1 | Frame boundary: byte is taken this cycle if valid |
| line_out | output | 1 | Encoded serial line, registered |

## Verification
The bench rebuilds the interval lengths from the toggle times on `line_out` and compares each against the frame expected for the sent byte. Asymmetric bytes such as 0x01 and 0x80 catch a design that serializes most significant bit first, and 0x00 and 0xFF catch one that holds the line at a level instead of toggling. Two bytes sent with valid held must give frames that abut exactly; a design that inserts an idle interval or raises ready twice per frame shows up as a shifted frame index or an extra ready count. A valid pulse in the middle of a frame must neither disturb the frame nor start a new one, and the first interval after reset must be exactly `BIT1_CYC` long with ready on its last cycle.

// File: rtl/biphase_pkg.sv
package biphase_pkg;

  typedef logic [7:0] byte_t;

  // Frame positions: 0 = start, 1..8 = data, 9 = stop
  localparam int unsigned FRAME_BITS = 10;
  localparam int unsigned STOP_POS   = FRAME_BITS - 1;
  localparam int unsigned DATA_BITS  = 8;

  // Interval reload value (length minus one) for a given bit
  function automatic int unsigned reload_for(input logic b,
                                             input int unsigned len1,
                                             input int unsigned len0);
    return b ? (len1 - 1) : (len0 - 1);
  endfunction

endpackage

// File: rtl/biphase_interval_timer.sv
module biphase_interval_timer #(
  parameter int unsigned BIT1_CYC = 4,
  parameter int unsigned BIT0_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic next_bit,   // value of the bit whose interval starts next
  output logic iv_end      // last cycle of the current interval
);
  import biphase_pkg::*;

  localparam int unsigned MAX_CYC = (BIT1_CYC > BIT0_CYC) ? BIT1_CYC : BIT0_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RLD1  = CW'(BIT1_CYC - 1);
  localparam logic [CW-1:0] RLD0  = CW'(BIT0_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign iv_end = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RLD1;                 // first interval after reset is a '1'
    end else if (iv_end) begin
      cnt_q <= CW'(reload_for(next_bit, BIT1_CYC, BIT0_CYC));
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Counter never exceeds the longest interval (R3)
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= ((RLD1 > RLD0) ? RLD1 : RLD0)));

endmodule

// File: rtl/biphase_frame_seq.sv
module biphase_frame_seq (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iv_end,
  input  logic                 in_valid,
  input  biphase_pkg::byte_t   in_data,
  output logic                 in_ready,
  output logic                 next_bit
);
  import biphase_pkg::*;

  localparam int unsigned PW = $clog2(FRAME_BITS);

  logic          busy_q;   // a frame is in flight
  logic [PW-1:0] pos_q;    // position of the bit now on the line
  byte_t         data_q;

  logic at_boundary;

  // Last interval of a frame, or an idle interval
  assign at_boundary = !busy_q || (pos_q == PW'(STOP_POS));
  assign in_ready    = iv_end && at_boundary;

  // Bit that follows the current one
  always_comb begin
    if (at_boundary) begin
      next_bit = !in_valid;               // start bit 0, or idle 1
    end else if (pos_q < PW'(DATA_BITS)) begin
      next_bit = data_q[pos_q[2:0]];      // position p+1 carries data bit p
    end else begin
      next_bit = 1'b1;                    // stop bit
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      data_q <= '0;
    end else if (iv_end) begin
      if (at_boundary) begin
        if (in_valid) begin
          busy_q <= 1'b1;
          pos_q  <= '0;
          data_q <= in_data;
        end else begin
          busy_q <= 1'b0;
        end
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  // Position stays inside a ten-bit frame (R1)
  assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (pos_q <= PW'(STOP_POS)));

endmodule

// File: rtl/biphase_line_drv.sv
module biphase_line_drv (
  input  logic clk,
  input  logic rst,
  input  logic iv_end,
  output logic line_out
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
    end else if (iv_end) begin
      line_q <= ~line_q;
    end
  end

  assign line_out = line_q;

endmodule

// File: rtl/biphase_line_enc.sv
module biphase_line_enc #(
  parameter int unsigned BIT1_CYC = 4,   // '1' interval, cycles (>= 2)
  parameter int unsigned BIT0_CYC = 8    // '0' interval, cycles (>= 2)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       line_out
);
  logic iv_end;
  logic next_bit;

  biphase_interval_timer #(
    .BIT1_CYC(BIT1_CYC),
    .BIT0_CYC(BIT0_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .next_bit (next_bit),
    .iv_end   (iv_end)
  );

  biphase_frame_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .iv_end   (iv_end),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .next_bit (next_bit)
  );

  biphase_line_drv u_drv (
    .clk      (clk),
    .rst      (rst),
    .iv_end   (iv_end),
    .line_out (line_out)
  );

  // Line moves only at the edge that closes an interval (R2)
  assert_toggle_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_out) |-> $past(iv_end));

  // Every interval end inverts the line (R2)
  assert_end_inverts_R2: assert property (@(posedge clk) disable iff (rst)
    iv_end |=> (line_out != $past(line_out)));

  // Ready lasts one cycle: after a handshake the next cycle is not a boundary (R6)
  assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> !in_ready);

endmodule

// File: tb/test_biphase_line_enc.sv
module test_biphase_line_enc;

  localparam int unsigned T1 = 4;
  localparam int unsigned T0 = 8;
  localparam int unsigned MAXI = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       line_out;

  int checks = 0;
  int failures = 0;

  // 50 MHz: 20 ns period
  always #10 clk = ~clk;

  biphase_line_enc #(.BIT1_CYC(T1), .BIT0_CYC(T0)) i_biphase_line_enc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .line_out (line_out)
  );

  // Monitor: interval lengths from toggle times, sampled at falling edges
  int   cyc = 0;
  int   last_t = 0;
  int   nint = 0;
  int   rdy_cnt = 0;
  logic prev = 1'b0;
  int   intv [0:MAXI-1];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      last_t <= cyc + 1;   // first post-reset falling edge counts as interval cycle 1
      prev   <= line_out;
    end else begin
      if (in_ready) rdy_cnt <= rdy_cnt + 1;
      if (line_out !== prev) begin
        if (nint < MAXI) intv[nint] <= cyc - last_t;
        nint   <= nint + 1;
        last_t <= cyc;
        prev   <= line_out;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic b);
    return b ? T1 : T0;
  endfunction

  task automatic wait_intervals(input int upto);
    while (nint < upto) @(negedge clk);
  endtask

  // Offer a byte, return index of its first interval and ready count before it
  task automatic send_byte(input logic [7:0] b, output int fs, output int rc);
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    fs = nint + 1;        // interval now ending is index nint
    rc = rdy_cnt;
    @(posedge clk);
    #2 in_valid = 1'b0;
  endtask

  task automatic check_frame(input string req, input int fs, input logic [7:0] b);
    wait_intervals(fs + 10);
    chk(req, "start interval", intv[fs], T0);
    for (int i = 0; i < 8; i++)
      chk(req, $sformatf("data bit %0d interval", i), intv[fs + 1 + i], len_of(b[i]));
    chk(req, "stop interval", intv[fs + 9], T1);
  endtask

  // R7: reset state and first interval
  task automatic t_reset();
    int n;
    @(posedge clk); #2 rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R7", "line during reset", int'(line_out), 0);
    chk("R7", "ready during reset", int'(in_ready), 0);
    @(posedge clk); #2 rst = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (in_ready) break;
    end
    chk("R7", "cycles to first ready", n, T1);
    chk("R7", "no toggle before first ready", nint, 0);
    wait_intervals(1);
    chk("R7", "first interval length", intv[0], T1);
  endtask

  // R5: idle keeps toggling at the '1' interval
  task automatic t_idle();
    int base = nint;
    wait_intervals(base + 6);
    for (int i = 0; i < 6; i++)
      chk("R5", $sformatf("idle interval %0d", i), intv[base + i], T1);
  endtask

  // R1 / R3: mixed bytes, bit order
  task automatic t_bytes();
    int fs, rc;
    logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
    for (int k = 0; k < 4; k++) begin
      send_byte(pats[k], fs, rc);
      check_frame("R1_R3", fs, pats[k]);
    end
  endtask

  // R4: identical bits still toggle every interval
  task automatic t_uniform();
    int fs, rc;
    send_byte(8'h00, fs, rc);
    check_frame("R4", fs, 8'h00);
    send_byte(8'hFF, fs, rc);
    check_frame("R4", fs, 8'hFF);
    chk("R4", "toggles in 0xFF frame", (nint >= fs + 10) ? 10 : nint - fs, 10);
  endtask

  // R6: held valid gives abutting frames, one ready per frame
  task automatic t_back_to_back();
    int fs1, fs2, rc1, rc2;
    send_byte(8'h96, fs1, rc1);
    send_byte(8'h69, fs2, rc2);
    chk("R6", "second frame abuts first", fs2, fs1 + 10);
    chk("R6", "ready pulses between handshakes", rc2 - rc1, 1);
    check_frame("R6", fs1, 8'h96);
    check_frame("R6", fs2, 8'h69);
  endtask

  // R8: mid-frame valid is ignored
  task automatic t_ignore();
    int fs, rc;
    send_byte(8'h0F, fs, rc);
    repeat (20) @(posedge clk);
    #2 in_valid = 1'b1; in_data = 8'hFF;
    repeat (5) @(posedge clk);
    #2 in_valid = 1'b0; in_data = 8'h00;
    check_frame("R8", fs, 8'h0F);
    wait_intervals(fs + 14);
    for (int i = 0; i < 4; i++)
      chk("R8", $sformatf("idle after frame %0d", i), intv[fs + 10 + i], T1);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_bytes();
    t_uniform();
    t_back_to_back();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule